// File: doc/BRIEF.md
# AC Line Loss Detector

This block decides that mains power has failed when the line-sense signal stops swinging. An external comparator pair, placed about the supply rail, drives a level that is high while the line voltage sits inside a narrow dead band around that rail. On a healthy AC line the level drops on every half-cycle, because the line swings out of the band. When the line stops swinging, the level stays high. The block counts periodic timing ticks while the level is high. If the level stays high for a set number of ticks, the block sets a sticky status flag and raises an interrupt request.

The window level is asynchronous to the system clock, so it is passed through a two-flop synchronizer first. Any sampled exit from the window resets the tick count to zero. Clearing the enable input holds the count at zero, and no detection can then happen. The status flag stays set after the line comes back, so software can poll it and clear it with a write-one-to-clear strobe. With the default tick count of 4 and a 1 ms tick, the delay from the last transition to the flag falls between 3 ms and 4 ms, plus the two synchronizer cycles.

Top module: `line_loss_det`

## Requirements
- R1: After reset, `status` and `irq` are both 0.
- R2: The window level reaches the counter only after two clock edges. A tick that falls in either of the first two clock cycles after `in_window` rises is not counted.
- R3: With `sense_en`=1 and the window level held high, `status` becomes 1 on the clock edge of the TICKS-th counted tick (default TICKS=4). After only TICKS-1 ticks it stays 0.
- R4: If the synchronized window level is sampled low, the count restarts from zero. TICKS further ticks are then needed after the level returns.
- R5: While `sense_en`=0, the count is held at zero and `status` cannot be set. Ticks counted before the enable dropped are discarded.
- R6: Once set, `status` stays 1 when the window level falls again (line power restored), and it stays 1 for any number of further ticks.
- R7: A one-cycle pulse on `status_clr` (1 = clear) in a cycle without a detection makes `status` 0 after the next clock edge.
- R8: Only one detection happens per continuous dwell in the window. After a clear, further ticks in the same dwell do not set `status` again. A new detection needs an exit from the window and TICKS ticks after re-entry.
- R9: `irq` is 1 exactly when `status` is 1 and `sense_en` is 1. Dropping `sense_en` masks `irq` but keeps `status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle periodic timing pulse |
| sense_en | input | 1 | Detection enable (1 = enabled) |
| in_window | input | 1 | Asynchronous dead-band level (1 = inside the band) |
| status_clr | input | 1 | Write-one-to-clear strobe for the status flag |
| status | output | 1 | Sticky line-loss flag |
| irq | output | 1 | Interrupt request, level high |

## Verification
A change on `in_window` takes effect on the counter two clock edges later. The bench therefore waits three cycles after each window change before it issues a tick. `status` is a register that loads on the same edge that samples the final counted tick, so the bench reads it at the falling edge right after that tick. `irq` is combinational from `status` and `sense_en`, so it is read at the falling edge after a change of enable. A clear is due one edge after the strobe, and every check samples at a falling edge, half a cycle away from the edge that updates the outputs.

// File: rtl/line_loss_det.sv
module line_loss_det #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sense_en,
  input  logic in_window,
  input  logic status_clr,
  output logic status,
  output logic irq
);
  localparam int CW = $clog2(TICKS + 1);

  logic          win_s1, win_s2;
  logic [CW-1:0] cnt;
  logic          armed;
  logic          hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      win_s1 <= 1'b0;
      win_s2 <= 1'b0;
    end else begin
      win_s1 <= in_window;
      win_s2 <= win_s1;
    end

  assign armed = sense_en && win_s2;
  assign hit   = armed && tick && (cnt == CW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cnt <= '0;
    else if (!armed)
      cnt <= '0;
    else if (tick && cnt != CW'(TICKS))
      cnt <= cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      status <= 1'b0;
    else if (hit)
      status <= 1'b1;
    else if (status_clr)
      status <= 1'b0;

  assign irq = status && sense_en;
endmodule

module line_loss_det_chk #(
  parameter int TICKS = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          sense_en,
  input logic          status_clr,
  input logic          status,
  input logic          irq,
  input logic [CW-1:0] cnt
);
  // R3
  status_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !status ##1 status |-> $past(tick) && $past(sense_en));
  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr && !tick |=> !status);
  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status && !status_clr |=> status);
  // R5
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_en |=> cnt == '0);
  // R9
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sense_en |-> !irq);
  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(TICKS));
endmodule

bind line_loss_det line_loss_det_chk #(.TICKS(TICKS), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sense_en(sense_en),
  .status_clr(status_clr), .status(status), .irq(irq), .cnt(cnt));

// File: tb/sim_line_loss_det.sv
module sim_line_loss_det;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, sense_en = 1'b0;
  logic in_window = 1'b0, status_clr = 1'b0;
  logic status, irq;
  int   errs = 0, total = 0;
  bit   done = 1'b0;

  line_loss_det #(.TICKS(4)) u0 (.*);

  always #4 clk = ~clk;

  // {en, win, ticks[5:0], expected status}
  localparam logic [8:0] VEC [6] = '{
    {1'b1, 1'b1, 6'd3,  1'b0},
    {1'b1, 1'b1, 6'd4,  1'b1},
    {1'b0, 1'b1, 6'd6,  1'b0},
    {1'b1, 1'b0, 6'd8,  1'b0},
    {1'b1, 1'b1, 6'd10, 1'b1},
    {1'b1, 1'b1, 6'd1,  1'b0}
  };

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic pulse_ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic clear_all();
    in_window = 1'b0; status_clr = 1'b1; @(negedge clk);
    status_clr = 1'b0; settle();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errs++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status, 1'b0);
    chk("R1 irq", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R5 vector walk
    for (int v = 0; v < 6; v++) begin
      clear_all();
      sense_en = VEC[v][8];
      in_window = VEC[v][7];
      settle();
      pulse_ticks(int'(VEC[v][6:1]));
      chk("R3/R5 vector status", status, VEC[v][0]);
      chk("R9 vector irq", irq, VEC[v][0] & VEC[v][8]);
    end

    // R2: ticks during sync latency are ignored
    clear_all(); sense_en = 1'b1;
    in_window = 1'b1; tick = 1'b1;
    repeat (2) @(negedge clk);
    tick = 1'b0; @(negedge clk);
    pulse_ticks(3);
    chk("R2 early ticks ignored", status, 1'b0);
    pulse_ticks(1);
    chk("R2 fourth counted tick", status, 1'b1);

    // R6: sticky after line returns
    in_window = 1'b0; settle();
    pulse_ticks(5);
    chk("R6 sticky", status, 1'b1);

    // R7: write-one-to-clear
    status_clr = 1'b1; @(negedge clk); status_clr = 1'b0;
    chk("R7 cleared", status, 1'b0);

    // R4: exit restarts count
    in_window = 1'b1; settle();
    pulse_ticks(3);
    in_window = 1'b0; settle();
    in_window = 1'b1; settle();
    pulse_ticks(3);
    chk("R4 restart", status, 1'b0);
    pulse_ticks(1);
    chk("R4 full dwell", status, 1'b1);

    // R8: one detection per dwell
    status_clr = 1'b1; @(negedge clk); status_clr = 1'b0;
    pulse_ticks(6);
    chk("R8 no refire", status, 1'b0);
    in_window = 1'b0; settle();
    in_window = 1'b1; settle();
    pulse_ticks(4);
    chk("R8 new dwell", status, 1'b1);

    // R9: enable masks irq, keeps status
    sense_en = 1'b0; @(negedge clk);
    chk("R9 irq masked", irq, 1'b0);
    chk("R9 status kept", status, 1'b1);
    sense_en = 1'b1; @(negedge clk);
    chk("R9 irq unmasked", irq, 1'b1);

    // R5: disable mid-count discards progress
    clear_all(); in_window = 1'b1; settle();
    pulse_ticks(3);
    sense_en = 1'b0; @(negedge clk);
    sense_en = 1'b1; @(negedge clk);
    pulse_ticks(1);
    chk("R5 discard on disable", status, 1'b0);
    pulse_ticks(3);
    chk("R5 detect after re-enable", status, 1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule